// File: doc/BRIEF.md
# Transient Extremum Timing Capture

This block watches the thermometer-coded output of a bank of eight comparators placed in a window around a regulation reference. It locates the deepest point of an output-voltage excursion after a load step. It does this with coarse threshold crossings only: no sampled converter and no current sensing. A fast clock stands in for a chain of delay cells, one tick per cell. A counter measures how long the output dwells between successive changes of comparator state.

The number of asserted comparators gives a level from 0 to 8, and the reference sits at level 4. When the level moves more than two steps away from the reference, the block starts tracking. It records whether the excursion is a dip or an overshoot. While the deviation keeps growing, each new level restarts the dwell counter. The first step back toward the reference marks the extremum. At that point the block reports, in one cycle, the largest deviation reached and the time spent at that deepest level. A downstream sequence calculator uses these two values to place the valley instant and size its switching times.

Top module: `xtr_extremum_capture`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to idle. After that edge, `extPulse`, `inTransient`, `dirOver`, `extMag` and `extInterval` are all 0, and the dwell counter is held at zero.
- R2: The level is the count of asserted bits of `cmpTherm`, and the deviation is that level minus 4. From idle, an excursion is recognised only when the absolute deviation is 3 or more. `inTransient` goes high after the edge that samples such a level. Deviations of 1 or 2 leave the block idle.
- R3: `dirOver` is set to 1 for a level above 4 and to 0 for a level below 4, at the edge where the excursion is recognised. It holds while the excursion is tracked.
- R4: During tracking, the first sampled level that is closer to the reference than the deepest level so far marks the extremum. `extPulse` is high for exactly the one cycle after that edge.
- R5: Together with `extPulse`, `extMag` shows the largest absolute deviation reached (3 or 4). It keeps that value until the next pulse or reset.
- R6: Together with `extPulse`, `extInterval` shows the number of rising edges at which the deepest level was sampled. The counter restarts at 1 on every level change during tracking, so a one-edge dwell reads 1.
- R7: The dwell count saturates at 64 instead of wrapping. A deepest level held for 64 edges or more reads 64.
- R8: After an extremum, no further pulse occurs, even if the deviation grows again, until the level returns to exactly 4. The block then goes idle and `inTransient` falls.
- R9: Overshoots are handled the same way as dips, with deviation measured as level minus 4 instead of 4 minus level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period equals one delay unit |
| rst | input | 1 | Synchronous reset, active high |
| cmpTherm | input | 8 | Comparator outputs, thermometer coded; bit k high means above threshold k |
| extPulse | output | 1 | One-cycle strobe marking the detected extremum |
| dirOver | output | 1 | 1 for an overshoot, 0 for a dip |
| extMag | output | 3 | Largest absolute deviation in quantization steps |
| extInterval | output | 7 | Dwell time at the deepest level, in clock ticks |
| inTransient | output | 1 | High while an excursion is tracked or recovering |

## Verification
The hardest cases to reach from the ports are dwell saturation and a second deepening during recovery. Both need the comparator level to stay put for long stretches after the block has committed to a decision. The stimulus holds the deepest level for 100 edges before stepping back. It then drives the level deeper again while the block waits for the reference. A behavioural reference model, checked every clock, confirms that no second pulse appears and that the reported dwell stays pinned at 64.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TRACK   = 2'd1,
    ST_RECOVER = 2'd2
  } xtrState_t;

  typedef struct packed {
    logic arm;     // start tracking at the current level
    logic deepen;  // new deepest level, restart dwell count
    logic emit;    // publish extremum, stop counting
    logic count;   // keep counting dwell ticks
  } xtrStrobe_t;
endpackage

// File: rtl/xtr_datapath.sv
module xtr_datapath
  import xtr_pkg::*;
#(
  parameter int NUM_THR    = 8,
  parameter int TRIG_STEPS = 2,
  parameter int CNT_MAX    = 64,
  localparam int MID   = NUM_THR / 2,
  localparam int MAG_W = $clog2(MID + 1),
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] cmpTherm,
  input  xtrStrobe_t         strobe,
  output logic               bigDev,
  output logic               atRef,
  output logic               deeper,
  output logic               retreat,
  output logic               dirOver,
  output logic [MAG_W-1:0]   extMag,
  output logic [CNT_W-1:0]   extInterval
);
  int levelI;
  int devI;
  int absI;
  int towardI;

  logic [CNT_W-1:0] runCnt;
  logic [MAG_W-1:0] peakMag;
  logic             dirReg;
  logic [MAG_W-1:0] magQ;
  logic [CNT_W-1:0] intQ;

  always_comb begin
    levelI = 0;
    for (int k = 0; k < NUM_THR; k++) begin
      levelI = levelI + int'(cmpTherm[k]);
    end
    devI    = levelI - MID;
    absI    = (devI < 0) ? -devI : devI;
    towardI = dirReg ? devI : -devI;
  end

  assign bigDev  = absI > TRIG_STEPS;
  assign atRef   = devI == 0;
  assign deeper  = towardI > int'(peakMag);
  assign retreat = towardI < int'(peakMag);

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt  <= '0;
      peakMag <= '0;
      dirReg  <= 1'b0;
      magQ    <= '0;
      intQ    <= '0;
    end else if (strobe.arm) begin
      dirReg  <= devI > 0;
      peakMag <= MAG_W'(absI);
      runCnt  <= CNT_W'(1);
    end else if (strobe.deepen) begin
      peakMag <= MAG_W'(towardI);
      runCnt  <= CNT_W'(1);
    end else if (strobe.emit) begin
      magQ   <= peakMag;
      intQ   <= runCnt;
      runCnt <= '0;
    end else if (strobe.count) begin
      if (runCnt < CNT_W'(CNT_MAX)) begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end else begin
      runCnt <= '0;
    end
  end

  assign dirOver     = dirReg;
  assign extMag      = magQ;
  assign extInterval = intQ;
endmodule

// File: rtl/xtr_control.sv
module xtr_control
  import xtr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bigDev,
  input  logic       atRef,
  input  logic       deeper,
  input  logic       retreat,
  output xtrStrobe_t strobe,
  output logic       extPulse,
  output logic       inTransient
);
  xtrState_t state;
  xtrState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (bigDev) begin
          strobe.arm = 1'b1;
          stateNext  = ST_TRACK;
        end
      end
      ST_TRACK: begin
        if (deeper) begin
          strobe.deepen = 1'b1;
        end else if (retreat) begin
          strobe.emit = 1'b1;
          stateNext   = ST_RECOVER;
        end else begin
          strobe.count = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (atRef) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      extPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      extPulse <= strobe.emit;
    end
  end

  assign inTransient = state != ST_IDLE;
endmodule

// File: rtl/xtr_extremum_capture.sv
module xtr_extremum_capture
  import xtr_pkg::*;
#(
  parameter int NUM_THR    = 8,
  parameter int TRIG_STEPS = 2,
  parameter int CNT_MAX    = 64,
  localparam int MAG_W = $clog2(NUM_THR / 2 + 1),
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] cmpTherm,
  output logic               extPulse,
  output logic               dirOver,
  output logic [MAG_W-1:0]   extMag,
  output logic [CNT_W-1:0]   extInterval,
  output logic               inTransient
);
  xtrStrobe_t strobe;
  logic bigDev, atRef, deeper, retreat;

  xtr_control u_ctl (
    .clk(clk), .rst(rst),
    .bigDev(bigDev), .atRef(atRef), .deeper(deeper), .retreat(retreat),
    .strobe(strobe), .extPulse(extPulse), .inTransient(inTransient)
  );

  xtr_datapath #(
    .NUM_THR(NUM_THR), .TRIG_STEPS(TRIG_STEPS), .CNT_MAX(CNT_MAX)
  ) u_dp (
    .clk(clk), .rst(rst), .cmpTherm(cmpTherm), .strobe(strobe),
    .bigDev(bigDev), .atRef(atRef), .deeper(deeper), .retreat(retreat),
    .dirOver(dirOver), .extMag(extMag), .extInterval(extInterval)
  );
endmodule

// File: rtl/xtr_checker.sv
module xtr_checker #(
  parameter int NUM_THR    = 8,
  parameter int TRIG_STEPS = 2,
  parameter int CNT_MAX    = 64,
  localparam int MAG_W = $clog2(NUM_THR / 2 + 1),
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             extPulse,
  input logic             dirOver,
  input logic [MAG_W-1:0] extMag,
  input logic [CNT_W-1:0] extInterval,
  input logic             inTransient
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) extPulse |=> !extPulse); // R4
  AST_PULSE_AFTER_TRACK: assert property (@(posedge clk) disable iff (rst) extPulse |-> $past(inTransient)); // R4
  AST_PULSE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst) extPulse |-> inTransient); // R8
  AST_MAG_ABOVE_TRIG: assert property (@(posedge clk) disable iff (rst) extPulse |-> (int'(extMag) > TRIG_STEPS)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !extPulse |-> ($stable(extMag) && $stable(extInterval))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) int'(extInterval) <= CNT_MAX); // R7
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst) (inTransient && $past(inTransient)) |-> $stable(dirOver)); // R3
endmodule

bind xtr_extremum_capture xtr_checker #(
  .NUM_THR(NUM_THR), .TRIG_STEPS(TRIG_STEPS), .CNT_MAX(CNT_MAX)
) u_chk (
  .clk(clk), .rst(rst), .extPulse(extPulse), .dirOver(dirOver),
  .extMag(extMag), .extInterval(extInterval), .inTransient(inTransient)
);

// File: tb/xtr_extremum_capture_bench.sv
`timescale 1ns/1ps
module xtr_extremum_capture_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cmpTherm = 8'h0F;
  logic       extPulse, dirOver, inTransient;
  logic [2:0] extMag;
  logic [6:0] extInterval;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xtr_extremum_capture u_xtr_extremum_capture (
    .clk(clk), .rst(rst), .cmpTherm(cmpTherm), .extPulse(extPulse),
    .dirOver(dirOver), .extMag(extMag), .extInterval(extInterval),
    .inTransient(inTransient)
  );

  task automatic checkVal(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int mSt = 0, mCnt = 0, mPeak = 0, mDir = 0, mPulse = 0, mMag = 0, mInt = 0;
  always @(posedge clk) begin
    int lvl, dev, mag, tw;
    lvl = $countones(cmpTherm);
    dev = lvl - 4;
    mag = (dev < 0) ? -dev : dev;
    if (rst) begin
      mSt = 0; mCnt = 0; mPeak = 0; mDir = 0; mPulse = 0; mMag = 0; mInt = 0;
    end else begin
      mPulse = 0;
      if (mSt == 0) begin
        if (mag > 2) begin
          mSt = 1; mDir = (dev > 0) ? 1 : 0; mPeak = mag; mCnt = 1;
        end
      end else if (mSt == 1) begin
        tw = (mDir == 1) ? dev : -dev;
        if (tw > mPeak) begin
          mPeak = tw; mCnt = 1;
        end else if (tw < mPeak) begin
          mPulse = 1; mMag = mPeak; mInt = mCnt; mSt = 2;
        end else if (mCnt < 64) begin
          mCnt++;
        end
      end else if (dev == 0) begin
        mSt = 0;
      end
    end
    #1;
    checkVal("R4 pulse", int'(extPulse), mPulse);
    checkVal("R5 magnitude", int'(extMag), mMag);
    checkVal("R6 interval", int'(extInterval), mInt);
    checkVal("R3 direction", int'(dirOver), mDir);
    checkVal("R2 inTransient", int'(inTransient), (mSt != 0) ? 1 : 0);
  end

  task automatic hold(int lvl, int n);
    for (int k = 0; k < 8; k++) cmpTherm[k] = (k < lvl);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R1 reset pulse", int'(extPulse), 0);
    checkVal("R1 reset mag", int'(extMag), 0);
    checkVal("R1 reset busy", int'(inTransient), 0);
    rst = 1'b0;

    // R2: small deviations stay idle
    hold(3, 3); hold(2, 5); hold(5, 2); hold(6, 4);
    checkVal("R2 small dev idle", int'(inTransient), 0);
    checkVal("R2 small dev no pulse", int'(extPulse), 0);
    hold(4, 2);

    // dip: 3 -> 1 (arm) -> 0 for 5 edges -> back to 1
    hold(3, 2); hold(1, 3);
    checkVal("R2 armed", int'(inTransient), 1);
    hold(0, 5); hold(1, 1);
    checkVal("R4 dip pulse", int'(extPulse), 1);
    checkVal("R5 dip mag", int'(extMag), 4);
    checkVal("R6 dip interval", int'(extInterval), 5);
    checkVal("R3 dip dir", int'(dirOver), 0);
    hold(1, 1);
    checkVal("R4 pulse single", int'(extPulse), 0);
    checkVal("R5 mag held", int'(extMag), 4);
    hold(4, 1);
    checkVal("R8 back to idle", int'(inTransient), 0);

    // R9 overshoot
    hold(7, 6); hold(6, 1);
    checkVal("R9 over pulse", int'(extPulse), 1);
    checkVal("R9 over mag", int'(extMag), 3);
    checkVal("R9 over interval", int'(extInterval), 6);
    checkVal("R3 over dir", int'(dirOver), 1);
    hold(4, 2);

    // R6 one-edge dwell
    hold(1, 1); hold(0, 1); hold(1, 1);
    checkVal("R6 short interval", int'(extInterval), 1);
    checkVal("R6 short pulse", int'(extPulse), 1);
    hold(4, 2);

    // R7 saturation, then R8 deepening during recovery
    hold(0, 100); hold(2, 1);
    checkVal("R7 saturated", int'(extInterval), 64);
    hold(0, 5);
    checkVal("R8 no second pulse", int'(extPulse), 0);
    checkVal("R8 still busy", int'(inTransient), 1);
    hold(4, 1);
    checkVal("R8 idle at ref", int'(inTransient), 0);

    // R1 reset mid-transient
    hold(8, 3);
    checkVal("R1 pre-reset busy", int'(inTransient), 1);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R1 mid reset busy", int'(inTransient), 0);
    checkVal("R1 mid reset interval", int'(extInterval), 0);
    checkVal("R1 mid reset dir", int'(dirOver), 0);
    hold(4, 1);
    rst = 1'b0;
    hold(4, 3);
    checkVal("R1 idle after reset", int'(inTransient), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule